// File: doc/BRIEF.md
# Octal UART Interrupt Source Aggregator

This block collects the interrupt conditions of eight UART channels and presents them as one global status view. Each channel contributes two level conditions (receive data at or above its trigger level, and receive timeout) and several edge-type events (line error bits, transmit ready, modem or handshake delta, and software flow or special character detect). Channel 0 also takes a timer timeout event. Edge-type events are held in sticky pending flags. Each flag is cleared by a one-cycle read strobe for the status register that owns it.

For each channel, the block reports only the most urgent pending source, as a 3-bit code. The codes are packed into a 24-bit vector, which a register file can expose as three 8-bit words. The block also produces one summary bit per channel and a single combined interrupt line. Level conditions reach the outputs in the same cycle. A sticky event becomes visible in the cycle after its pulse, and leaves in the cycle after the read strobe that clears it.

Top module: `uart_irq_hub`

## Requirements
- R1: Channel n's code occupies `irq_code_o[3n+2:3n]`, so bits [7:0], [15:8] and [23:16] form the three 8-bit encoded words. The summary bit `irq_sum_o[n]` is the OR of channel n's code bits, and `irq_o` is the OR of all summary bits. Codes 101 and 110 never appear.
- R2: While `rx_ready_i[n]` is high, channel n reports code 001. The code follows the level combinationally and is no longer reported once the level drops.
- R3: A pulse on any of the four line error bits `line_err_i[4n+3:4n]` sets a pending flag that reports code 001. The flag clears only on `rd_lsr_i[n]`.
- R4: While `rx_timeout_i[n]` is high, channel n reports code 010. The code follows the level and is no longer reported once the level drops.
- R5: A `tx_ready_i[n]` pulse sets a pending flag that reports code 011. The flag clears on `rd_isr_i[n]` and is unaffected by the other read strobes.
- R6: A `modem_delta_i[n]` pulse sets a pending flag that reports code 100. The flag clears on `rd_msr_i[n]` only.
- R7: A `flow_char_i[n]` pulse sets a pending flag that reports code 100. The flag clears on `rd_isr_i[n]` only.
- R8: A `timer_evt_i` pulse sets a flag that reports code 111 on channel 0 only. The flag clears on `rd_timer_i`. No other channel ever reports 111.
- R9: Priority runs from highest to lowest as 001, 010, 011, 100, 111. Each channel reports only the highest-priority pending source.
- R10: If a set event and the clear strobe for the same flag arrive in the same cycle, the flag ends up set.
- R11: After reset, all pending flags are clear. With the level inputs low, every code, every summary bit and `irq_o` read 0.
- R12: A read strobe for channel n has no effect on the flags of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_ready_i | input | 8 | Per-channel level: receive FIFO at or above its trigger level |
| rx_timeout_i | input | 8 | Per-channel level: receive timeout active |
| line_err_i | input | 32 | Four line error event bits per channel; channel n uses [4n+3:4n] |
| tx_ready_i | input | 8 | Per-channel transmit ready event pulse |
| modem_delta_i | input | 8 | Per-channel modem or handshake delta event pulse |
| flow_char_i | input | 8 | Per-channel software flow or special character event pulse |
| timer_evt_i | input | 1 | Timer timeout event pulse (channel 0) |
| rd_lsr_i | input | 8 | Per-channel line status register read strobe |
| rd_isr_i | input | 8 | Per-channel interrupt status register read strobe |
| rd_msr_i | input | 8 | Per-channel modem status register read strobe |
| rd_timer_i | input | 1 | Timer control register read strobe |
| irq_code_o | output | 24 | Packed 3-bit source codes, channel n at [3n+2:3n] |
| irq_sum_o | output | 8 | Per-channel interrupt pending summary |
| irq_o | output | 1 | OR of all channel summaries |

## Verification
The assertions assume that the event and strobe inputs are synchronous to `clk_i` and are sampled once per cycle. They also assume that a pulse lasting several cycles simply sets its flag again on each of those cycles. The bench drives every input on the falling edge, so all inputs are stable at the rising edge. It raises events, strobes and levels in any mix, including the same-cycle set and clear case. The bench model is updated on the rising edge from exactly the inputs the design sees.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned LERR_W = 4;
  localparam int unsigned FLAG_W = 5;

  // sticky flag slots
  localparam int unsigned F_LERR  = 0;
  localparam int unsigned F_TX    = 1;
  localparam int unsigned F_MODEM = 2;
  localparam int unsigned F_FLOW  = 3;
  localparam int unsigned F_TIMER = 4;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE  = 3'b000,
    CODE_RX    = 3'b001,
    CODE_RXTO  = 3'b010,
    CODE_TX    = 3'b011,
    CODE_MODEM = 3'b100,
    CODE_TIMER = 3'b111
  } irq_code_e;
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= set_i | (q & ~clr_i);
  end

  assign q_o = q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  p_clear_takes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/uart_irq_chan.sv
module uart_irq_chan
  import uart_irq_pkg::*;
#(
  parameter bit HAS_TIMER = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_lvl_i,
  input  logic              rxto_lvl_i,
  input  logic [LERR_W-1:0] lerr_i,
  input  logic              tx_evt_i,
  input  logic              modem_evt_i,
  input  logic              flow_evt_i,
  input  logic              timer_evt_i,
  input  logic              rd_lsr_i,
  input  logic              rd_isr_i,
  input  logic              rd_msr_i,
  input  logic              rd_timer_i,
  output logic [CODE_W-1:0] code_o,
  output logic              summary_o
);
  logic [FLAG_W-1:0] set_v, clr_v, pend;
  logic              tmr_en;
  irq_code_e         code;

  assign tmr_en = HAS_TIMER;

  always_comb begin
    set_v          = '0;
    set_v[F_LERR]  = |lerr_i;
    set_v[F_TX]    = tx_evt_i;
    set_v[F_MODEM] = modem_evt_i;
    set_v[F_FLOW]  = flow_evt_i;
    set_v[F_TIMER] = timer_evt_i & tmr_en;
    clr_v          = '0;
    clr_v[F_LERR]  = rd_lsr_i;
    clr_v[F_TX]    = rd_isr_i;
    clr_v[F_MODEM] = rd_msr_i;
    clr_v[F_FLOW]  = rd_isr_i;
    clr_v[F_TIMER] = rd_timer_i;
  end

  uart_irq_sticky #(.W(FLAG_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (pend)
  );

  // fixed priority, first match wins
  always_comb begin
    if (rx_lvl_i || pend[F_LERR])                  code = CODE_RX;
    else if (rxto_lvl_i)                           code = CODE_RXTO;
    else if (pend[F_TX])                           code = CODE_TX;
    else if (pend[F_MODEM] || pend[F_FLOW])        code = CODE_MODEM;
    else if (tmr_en && pend[F_TIMER])              code = CODE_TIMER;
    else                                           code = CODE_NONE;
  end

  assign code_o    = code;
  assign summary_o = |code_o;

  p_no_reserved_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != 3'b101) && (code_o != 3'b110));

  p_timer_only_ch0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == 3'b111) |-> HAS_TIMER);

  p_rx_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_lvl_i |-> (code_o == 3'b001));

  p_rxto_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxto_lvl_i && !rx_lvl_i) |-> (code_o == 3'b010 || code_o == 3'b001));

  p_lerr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lerr_i) |=> (code_o == 3'b001));

  p_tx_over_modem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_evt_i && !rd_isr_i && !rx_lvl_i && !rxto_lvl_i && !(|lerr_i) && !rd_lsr_i
     && !$past(1'b0)) |=> (code_o <= 3'b011));
endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
  import uart_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        rx_ready_i,
  input  logic [NUM_CH-1:0]        rx_timeout_i,
  input  logic [NUM_CH*LERR_W-1:0] line_err_i,
  input  logic [NUM_CH-1:0]        tx_ready_i,
  input  logic [NUM_CH-1:0]        modem_delta_i,
  input  logic [NUM_CH-1:0]        flow_char_i,
  input  logic                     timer_evt_i,
  input  logic [NUM_CH-1:0]        rd_lsr_i,
  input  logic [NUM_CH-1:0]        rd_isr_i,
  input  logic [NUM_CH-1:0]        rd_msr_i,
  input  logic                     rd_timer_i,
  output logic [NUM_CH*CODE_W-1:0] irq_code_o,
  output logic [NUM_CH-1:0]        irq_sum_o,
  output logic                     irq_o
);
  localparam int unsigned VEC_W = NUM_CH * CODE_W;

  logic [VEC_W-1:0] code_vec;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    uart_irq_chan #(.HAS_TIMER(n == 0)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rx_lvl_i    (rx_ready_i[n]),
      .rxto_lvl_i  (rx_timeout_i[n]),
      .lerr_i      (line_err_i[n*LERR_W +: LERR_W]),
      .tx_evt_i    (tx_ready_i[n]),
      .modem_evt_i (modem_delta_i[n]),
      .flow_evt_i  (flow_char_i[n]),
      .timer_evt_i ((n == 0) ? timer_evt_i : 1'b0),
      .rd_lsr_i    (rd_lsr_i[n]),
      .rd_isr_i    (rd_isr_i[n]),
      .rd_msr_i    (rd_msr_i[n]),
      .rd_timer_i  ((n == 0) ? rd_timer_i : 1'b0),
      .code_o      (code_vec[n*CODE_W +: CODE_W]),
      .summary_o   (irq_sum_o[n])
    );
  end

  assign irq_code_o = code_vec;
  assign irq_o      = |irq_sum_o;

  p_irq_has_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_code_o != '0));

  p_sum_matches_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_sum_o) <= NUM_CH && (irq_sum_o == '0) == (irq_code_o == '0));
endmodule

// File: tb/sim_uart_irq_hub.sv
module sim_uart_irq_hub;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]   rx_ready, rx_timeout, tx_ready, modem_delta, flow_char;
  logic [NCH-1:0]   rd_lsr, rd_isr, rd_msr;
  logic [NCH*4-1:0] line_err;
  logic             timer_evt, rd_timer;
  logic [NCH*3-1:0] irq_code;
  logic [NCH-1:0]   irq_sum;
  logic             irq;

  always #10 clk = ~clk;

  uart_irq_hub #(.NUM_CH(NCH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_ready_i(rx_ready), .rx_timeout_i(rx_timeout), .line_err_i(line_err),
    .tx_ready_i(tx_ready), .modem_delta_i(modem_delta), .flow_char_i(flow_char),
    .timer_evt_i(timer_evt), .rd_lsr_i(rd_lsr), .rd_isr_i(rd_isr),
    .rd_msr_i(rd_msr), .rd_timer_i(rd_timer),
    .irq_code_o(irq_code), .irq_sum_o(irq_sum), .irq_o(irq)
  );

  // behavioural reference
  bit [NCH-1:0] m_le, m_tx, m_md, m_fc;
  bit           m_tm;
  int           n_cmp = 0, n_bad = 0, cyc = 0;
  string        cur_req = "R11";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_le <= '0; m_tx <= '0; m_md <= '0; m_fc <= '0; m_tm <= 1'b0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        m_le[n] <= (line_err[4*n +: 4] != 4'b0) || (m_le[n] && !rd_lsr[n]);
        m_tx[n] <= tx_ready[n] || (m_tx[n] && !rd_isr[n]);
        m_md[n] <= modem_delta[n] || (m_md[n] && !rd_msr[n]);
        m_fc[n] <= flow_char[n] || (m_fc[n] && !rd_isr[n]);
      end
      m_tm <= timer_evt || (m_tm && !rd_timer);
    end
  end

  function automatic bit [2:0] exp_code(int n);
    if (rx_ready[n] || m_le[n]) return 3'd1;
    if (rx_timeout[n])          return 3'd2;
    if (m_tx[n])                return 3'd3;
    if (m_md[n] || m_fc[n])     return 3'd4;
    if (n == 0 && m_tm)         return 3'd7;
    return 3'd0;
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic compare();
    bit any = 1'b0;
    for (int n = 0; n < NCH; n++) begin
      bit [2:0] e = exp_code(n);
      any |= (e != 0);
      n_cmp++;
      if (irq_code[3*n +: 3] !== e) begin
        n_bad++;
        $display("FAIL %s ch%0d code act=%b exp=%b", cur_req, n, irq_code[3*n +: 3], e);
      end
      n_cmp++;
      if (irq_sum[n] !== (e != 0)) begin
        n_bad++;
        $display("FAIL R1 (%s) ch%0d summary act=%b exp=%b", cur_req, n, irq_sum[n], (e != 0));
      end
    end
    n_cmp++;
    if (irq !== any) begin
      n_bad++;
      $display("FAIL R1 (%s) irq act=%b exp=%b", cur_req, irq, any);
    end
  endtask

  task automatic tick(int k = 1);
    repeat (k) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic quiet();
    rx_ready = '0; rx_timeout = '0; line_err = '0; tx_ready = '0;
    modem_delta = '0; flow_char = '0; timer_evt = 1'b0;
    rd_lsr = '0; rd_isr = '0; rd_msr = '0; rd_timer = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp<=50000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    cur_req = "R11"; compare();
    rst_n = 1'b1; tick(2);

    cur_req = "R2";  rx_ready[2] = 1; tick(2); rx_ready[2] = 0; tick();

    cur_req = "R3";  line_err[4*5+3] = 1; tick(); line_err = '0; tick(2);
    rd_isr[5] = 1; rd_msr[5] = 1; tick(); quiet(); tick();
    rd_lsr[5] = 1; tick(); rd_lsr = '0; tick();

    cur_req = "R4";  rx_timeout[7] = 1; tick(2); rx_timeout[7] = 0; tick();

    cur_req = "R5";  tx_ready[1] = 1; tick(); tx_ready = '0; tick();
    rd_msr[1] = 1; rd_lsr[1] = 1; tick(); quiet(); tick();
    rd_isr[1] = 1; tick(); rd_isr = '0; tick();

    cur_req = "R6";  modem_delta[3] = 1; tick(); modem_delta = '0;
    rd_isr[3] = 1; tick(); rd_isr = '0; tick();
    rd_msr[3] = 1; tick(); rd_msr = '0; tick();

    cur_req = "R7";  flow_char[4] = 1; tick(); flow_char = '0;
    rd_msr[4] = 1; tick(); rd_msr = '0;
    rd_isr[4] = 1; tick(); rd_isr = '0; tick();

    cur_req = "R8";  timer_evt = 1; tick(); timer_evt = 0; tick(2);
    rd_timer = 1; tick(); rd_timer = 0; tick();

    cur_req = "R9";
    rx_ready[6] = 1; rx_timeout[6] = 1; tx_ready[6] = 1; modem_delta[6] = 1;
    line_err[4*6] = 1; tick();
    tx_ready = '0; modem_delta = '0; line_err = '0; tick();
    rx_ready[6] = 0; tick();
    rd_lsr[6] = 1; tick(); rd_lsr = '0; tick();
    rx_timeout[6] = 0; tick();
    rd_isr[6] = 1; tick(); rd_isr = '0; tick();
    timer_evt = 1; tx_ready[0] = 1; tick(); quiet(); tick();
    rd_isr[0] = 1; tick(); rd_isr = '0; tick();
    rd_msr[6] = 1; rd_timer = 1; tick(); quiet(); tick();

    cur_req = "R10";
    tx_ready[0] = 1; rd_isr[0] = 1; tick(); quiet(); tick();
    line_err[4*2+1] = 1; rd_lsr[2] = 1; tick(); quiet(); tick();
    timer_evt = 1; rd_timer = 1; tick(); quiet(); tick();
    rd_isr = '1; rd_lsr = '1; rd_timer = 1; tick(); quiet(); tick();

    cur_req = "R12";
    tx_ready[2] = 1; tx_ready[3] = 1; modem_delta[2] = 1; tick(); quiet();
    rd_isr[2] = 1; rd_msr[2] = 1; rd_lsr[3] = 1; tick(); quiet(); tick();
    rd_isr[3] = 1; tick(); quiet(); tick();

    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      rx_ready    = NCH'($urandom) & NCH'($urandom);
      rx_timeout  = NCH'($urandom) & NCH'($urandom);
      line_err    = (NCH*4)'($urandom) & (NCH*4)'($urandom) & (NCH*4)'($urandom) & (NCH*4)'($urandom);
      tx_ready    = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      modem_delta = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      flow_char   = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      timer_evt   = ($urandom % 8) == 0;
      rd_lsr      = NCH'($urandom) & NCH'($urandom);
      rd_isr      = NCH'($urandom) & NCH'($urandom);
      rd_msr      = NCH'($urandom) & NCH'($urandom);
      rd_timer    = ($urandom % 4) == 0;
      tick();
    end
    quiet(); tick(3);

    summary();
    $finish;
  end
endmodule